// File: doc/BRIEF.md
# Quadratic Delay and Phase Model Evaluator

This block tracks two quadratic models for one station over one integration: a geometric delay, stepped once per FFT, and a phase, stepped once per sample. The control side writes a coefficient set for the next integration into a shadow bank, one term at a time. A commit strobe moves the shadow bank into a staged bank. The next integration start pulse loads the staged bank into the running evaluators. While an integration runs, further writes and commits reach only the shadow and staged banks and leave the running models alone.

Each model keeps a value, a first difference and a constant second difference, so the datapath only adds. The control side supplies the coefficients already in forward-difference form: p(0), p(1)-p(0) and the second difference. The delay is 48 bits wide, and its low 8 bits are the fractional delay in 1/256 of a sample. That fraction goes to a later phase rotation at band centre. The upper 40 bits are the integer sample delay used to find the first sample to read. The phase is 64 bits wide, and its top 16 bits form a phase word in fractions of a turn for a quadrature mixer.

A two-state controller sequences the block. In ST_IDLE no model is valid and ticks are ignored. The transition T_ARM (integration start with a staged set pending) moves the block to ST_RUN. In ST_RUN the transition T_RELOAD (integration start with a set pending) stays in ST_RUN and reloads both models. The transition T_DROP (integration start with no set pending) returns the block to ST_IDLE.

Top module: `qm_eval`

## Requirements
- R1: After reset, dly_int, dly_frac and ph_word are 0, dly_valid and ph_valid are 0, and run is 0.
- R2: cfg_sel bit 2 selects the model (0 delay, 1 phase). cfg_sel bits 1:0 select the term (0 value, 1 first difference, 2 second difference). Codes 3 and 7 write nothing. A delay write takes cfg_data[47:0].
- R3: A coefficient write, and a commit, made during an integration leave the running outputs unchanged. Only the next int_start with a set pending loads new coefficients.
- R4: An int_start while a committed set is pending loads both models. In the next cycle the outputs show the staged values, dly_valid and ph_valid are 1 for that cycle, and run is 1.
- R5: In ST_RUN, an fft_tick without int_start adds the first difference to the delay value and the second difference to the first difference. The new delay appears, with dly_valid high, one cycle later. With no tick, the delay output holds and dly_valid is 0.
- R6: In ST_RUN, an smp_tick without int_start steps the phase model in the same way. The result appears, with ph_valid high, one cycle later. With no tick, the phase output holds.
- R7: dly_frac is delay bits 7:0 (1/256 sample) and dly_int is bits 47:8. Delay arithmetic wraps modulo 2^48.
- R8: ph_word is phase bits 63:48. Phase arithmetic wraps modulo 2^64.
- R9: An int_start with no set pending sends the block to ST_IDLE. From the next cycle, run, dly_valid and ph_valid are 0.
- R10: An int_start takes precedence over fft_tick and smp_tick in the same cycle. A cfg_commit in the same cycle as int_start leaves a new set pending for the following start, while the start uses the previously staged set.
- R11: In ST_IDLE, fft_tick and smp_tick change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Model (bit 2) and term (bits 1:0) select |
| cfg_data | input | 64 | Coefficient write data |
| cfg_commit | input | 1 | Copy the shadow bank to the staged bank and mark it pending |
| int_start | input | 1 | Integration start pulse |
| fft_tick | input | 1 | FFT boundary strobe, steps the delay model |
| smp_tick | input | 1 | Sample strobe, steps the phase model |
| dly_int | output | 40 | Integer sample delay |
| dly_frac | output | 8 | Fractional delay in 1/256 sample |
| dly_valid | output | 1 | New delay value this cycle |
| ph_word | output | 16 | Phase word in fractions of a turn |
| ph_valid | output | 1 | New phase word this cycle |
| run | output | 1 | Controller is in ST_RUN |

## Verification
The hardest situations to reach are the ones where several control events fall in the same cycle: a start together with both ticks, and a commit together with the start that consumes the previous commit. Reaching them needs an open integration and a pending set that is already staged. The directed stimulus builds that state first and then fires the coinciding strobes, so that a wrong priority shows up either as a stepped initial value or as a wrong state after the next start. A random phase then writes, commits, starts and ticks independently, against a behavioural model compared on every clock. Some values are seeded next to 2^48 and 2^64 so that the wrap of both accumulators is exercised.

// File: rtl/qm_pkg.sv
package qm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } qm_state_e;

    localparam int SEL_W   = 3;
    localparam int N_TERMS = 3;
endpackage

// File: rtl/qm_coef_bank.sv
module qm_coef_bank #(
    parameter int   W      = 48,
    parameter int   DATA_W = 64,
    parameter logic POLY   = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [qm_pkg::SEL_W-1:0] cfg_sel,
    input  logic [DATA_W-1:0]       cfg_data,
    input  logic                    cfg_commit,
    output logic [W-1:0]            stg_v,
    output logic [W-1:0]            stg_d1,
    output logic [W-1:0]            stg_d2
);
    // Term slots: 0 value, 1 first difference, 2 second difference
    for (genvar t = 0; t < qm_pkg::N_TERMS; t++) begin : g_term
        logic [W-1:0] shadow_q;
        logic [W-1:0] staged_q;
        logic         hit;

        assign hit = cfg_we && (cfg_sel[2] == POLY) && (cfg_sel[1:0] == 2'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                staged_q <= '0;
            end else begin
                if (hit) begin
                    shadow_q <= cfg_data[W-1:0];
                end
                if (cfg_commit) begin
                    staged_q <= shadow_q;
                end
            end
        end
    end

    assign stg_v  = g_term[0].staged_q;
    assign stg_d1 = g_term[1].staged_q;
    assign stg_d2 = g_term[2].staged_q;
endmodule

// File: rtl/qm_fwd_diff.sv
module qm_fwd_diff #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] init_v,
    input  logic [W-1:0] init_d1,
    input  logic [W-1:0] init_d2,
    output logic [W-1:0] acc_o,
    output logic         vld_o
);
    logic [W-1:0] d1_q;
    logic [W-1:0] d2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o <= '0;
            d1_q  <= '0;
            d2_q  <= '0;
            vld_o <= 1'b0;
        end else if (load) begin
            acc_o <= init_v;
            d1_q  <= init_d1;
            d2_q  <= init_d2;
            vld_o <= 1'b1;
        end else if (step) begin
            acc_o <= acc_o + d1_q;
            d1_q  <= d1_q + d2_q;
            vld_o <= 1'b1;
        end else begin
            vld_o <= 1'b0;
        end
    end
endmodule

// File: rtl/qm_ctrl.sv
module qm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic int_start,
    input  logic cfg_commit,
    input  logic fft_tick,
    input  logic smp_tick,
    output logic load,
    output logic dly_step,
    output logic ph_step,
    output logic run_o,
    output logic pend_o
);
    import qm_pkg::*;

    qm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_commit) begin
                pend_o <= 1'b1;
            end else if (int_start) begin
                pend_o <= 1'b0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (int_start && pend_o)  state_d = ST_RUN;   // T_ARM
            ST_RUN:  if (int_start && !pend_o) state_d = ST_IDLE;  // T_DROP
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = int_start && pend_o;
        dly_step = 1'b0;
        ph_step  = 1'b0;
        run_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_o = 1'b0;
            end
            ST_RUN: begin
                run_o    = 1'b1;
                dly_step = fft_tick && !int_start;
                ph_step  = smp_tick && !int_start;
            end
            default: run_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/qm_eval.sv
module qm_eval #(
    parameter int DLY_W    = 48,
    parameter int PH_W     = 64,
    parameter int FRAC_W   = 8,
    parameter int PH_OUT_W = 16,
    parameter int DATA_W   = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_sel,
    input  logic [DATA_W-1:0]       cfg_data,
    input  logic                    cfg_commit,
    input  logic                    int_start,
    input  logic                    fft_tick,
    input  logic                    smp_tick,
    output logic [DLY_W-FRAC_W-1:0] dly_int,
    output logic [FRAC_W-1:0]       dly_frac,
    output logic                    dly_valid,
    output logic [PH_OUT_W-1:0]     ph_word,
    output logic                    ph_valid,
    output logic                    run
);
    localparam int INT_W = DLY_W - FRAC_W;

    logic             load, dly_step, ph_step, pend;
    logic [DLY_W-1:0] d_v, d_d1, d_d2, dly_acc;
    logic [PH_W-1:0]  p_v, p_d1, p_d2, ph_acc;

    qm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .int_start(int_start), .cfg_commit(cfg_commit),
        .fft_tick(fft_tick), .smp_tick(smp_tick), .load(load),
        .dly_step(dly_step), .ph_step(ph_step), .run_o(run), .pend_o(pend)
    );

    qm_coef_bank #(.W(DLY_W), .DATA_W(DATA_W), .POLY(1'b0)) u_dly_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit),
        .stg_v(d_v), .stg_d1(d_d1), .stg_d2(d_d2)
    );

    qm_coef_bank #(.W(PH_W), .DATA_W(DATA_W), .POLY(1'b1)) u_ph_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit),
        .stg_v(p_v), .stg_d1(p_d1), .stg_d2(p_d2)
    );

    qm_fwd_diff #(.W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(load), .step(dly_step),
        .init_v(d_v), .init_d1(d_d1), .init_d2(d_d2),
        .acc_o(dly_acc), .vld_o(dly_valid)
    );

    qm_fwd_diff #(.W(PH_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .load(load), .step(ph_step),
        .init_v(p_v), .init_d1(p_d1), .init_d2(p_d2),
        .acc_o(ph_acc), .vld_o(ph_valid)
    );

    assign dly_frac = dly_acc[FRAC_W-1:0];
    assign dly_int  = dly_acc[DLY_W-1 -: INT_W];
    assign ph_word  = ph_acc[PH_W-1 -: PH_OUT_W];
endmodule

// File: rtl/qm_eval_chk.sv
module qm_eval_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        int_start,
    input logic        fft_tick,
    input logic        smp_tick,
    input logic        pend,
    input logic        run,
    input logic        dly_valid,
    input logic        ph_valid,
    input logic [39:0] dly_int,
    input logic [7:0]  dly_frac,
    input logic [15:0] ph_word
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dly_valid && !ph_valid && !run));

    a_r4_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (int_start && pend) |=> (run && dly_valid && ph_valid));

    a_r9_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (int_start && !pend) |=> !run);

    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!dly_valid && !ph_valid));

    a_r5_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fft_tick && !int_start) |=> dly_valid);

    a_r5_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_start && !fft_tick) |=> $stable({dly_int, dly_frac}));

    a_r6_ph_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_start && !smp_tick) |=> $stable(ph_word));
endmodule

bind qm_eval qm_eval_chk u_chk (
    .clk(clk), .rst_n(rst_n), .int_start(int_start), .fft_tick(fft_tick),
    .smp_tick(smp_tick), .pend(pend), .run(run), .dly_valid(dly_valid),
    .ph_valid(ph_valid), .dly_int(dly_int), .dly_frac(dly_frac), .ph_word(ph_word)
);

// File: tb/qm_eval_test.sv
`timescale 1ns/1ps
module qm_eval_test;
    localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_commit = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [63:0] cfg_data = '0;
    logic        int_start = 1'b0, fft_tick = 1'b0, smp_tick = 1'b0;
    logic [39:0] dly_int;
    logic [7:0]  dly_frac;
    logic        dly_valid, ph_valid, run;
    logic [15:0] ph_word;

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    qm_eval uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cfg_commit(cfg_commit), .int_start(int_start),
        .fft_tick(fft_tick), .smp_tick(smp_tick), .dly_int(dly_int),
        .dly_frac(dly_frac), .dly_valid(dly_valid), .ph_word(ph_word),
        .ph_valid(ph_valid), .run(run)
    );

    // Behavioural reference model
    logic [63:0] m_sh [8];
    logic [63:0] m_st [8];
    bit          m_pend, m_run, m_dv, m_pv;
    logic [63:0] m_dacc, m_dd1, m_dd2, m_pacc, m_pd1, m_pd2;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_st[i] = 0; end
            m_pend = 0; m_run = 0; m_dv = 0; m_pv = 0;
            m_dacc = 0; m_dd1 = 0; m_dd2 = 0; m_pacc = 0; m_pd1 = 0; m_pd2 = 0;
        end else begin
            if (int_start) begin
                if (m_pend) begin
                    m_dacc = m_st[0]; m_dd1 = m_st[1]; m_dd2 = m_st[2];
                    m_pacc = m_st[4]; m_pd1 = m_st[5]; m_pd2 = m_st[6];
                    m_run = 1; m_dv = 1; m_pv = 1; m_pend = 0;
                end else begin
                    m_run = 0; m_dv = 0; m_pv = 0;
                end
            end else if (m_run) begin
                m_dv = fft_tick;
                if (fft_tick) begin
                    m_dacc = (m_dacc + m_dd1) & M48;
                    m_dd1  = (m_dd1 + m_dd2) & M48;
                end
                m_pv = smp_tick;
                if (smp_tick) begin
                    m_pacc = m_pacc + m_pd1;
                    m_pd1  = m_pd1 + m_pd2;
                end
            end else begin
                m_dv = 0; m_pv = 0;
            end
            if (cfg_commit) begin
                for (int i = 0; i < 8; i++) m_st[i] = m_sh[i];
                m_pend = 1;
            end
            if (cfg_we && cfg_sel[1:0] != 2'd3)
                m_sh[cfg_sel] = cfg_sel[2] ? cfg_data : (cfg_data & M48);
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R5 delay integer", 64'(dly_int), (m_dacc >> 8) & 64'hFF_FFFF_FFFF);
            check("R7 delay fraction", 64'(dly_frac), m_dacc & 64'hFF);
            check("R8 phase word", 64'(ph_word), m_pacc >> 48);
            check("R4 delay valid", 64'(dly_valid), 64'(m_dv));
            check("R6 phase valid", 64'(ph_valid), 64'(m_pv));
            check("R9 run state", 64'(run), 64'(m_run));
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    // Drive one cycle at the falling edge, return at the next falling edge
    task automatic cyc(input bit we, input logic [2:0] sel, input logic [63:0] d,
                       input bit cm, input bit st, input bit ft, input bit sm);
        cfg_we = we; cfg_sel = sel; cfg_data = d; cfg_commit = cm;
        int_start = st; fft_tick = ft; smp_tick = sm;
        @(negedge clk);
        cfg_we = 0; cfg_commit = 0; int_start = 0; fft_tick = 0; smp_tick = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] d);
        cyc(1, sel, d, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset dly_int", 64'(dly_int), 0);
        check("R1 reset ph_word", 64'(ph_word), 0);
        check("R1 reset valids/run", {61'd0, dly_valid, ph_valid, run}, 0);
        cmp_en = 1'b1;

        // R11 ticks in idle
        cyc(0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check("R11 idle ticks delay", {dly_int, dly_frac}, 0);
        check("R11 idle ticks phase", 64'(ph_word), 0);

        // Set A
        wr(3'd0, 64'h0000_0000_0012_3456);
        wr(3'd1, 64'h180);
        wr(3'd2, 64'h2);
        wr(3'd4, 64'h4000_0000_0000_0000);
        wr(3'd5, 64'h0001_0000_0000_0000);
        wr(3'd6, 64'h0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R4 start delay int", 64'(dly_int), 64'h1234);
        check("R4 start delay frac", 64'(dly_frac), 64'h56);
        check("R4 start phase", 64'(ph_word), 64'h4000);
        check("R4 start valids/run", {61'd0, dly_valid, ph_valid, run}, 64'h7);

        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R5 first tick", {dly_int, dly_frac}, 64'h12_35D6);
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R5 hold no tick", {dly_int, dly_frac, 7'd0, dly_valid}, {48'h12_35D6, 8'h00});
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R5 second tick", {dly_int, dly_frac}, 64'h12_3758);
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 1);
        check("R6 three samples", 64'(ph_word), 64'h4003);

        // R3: write without commit, then commit, during the run
        wr(3'd0, 64'hFFFF);
        wr(3'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        wr(3'd7, 64'hBEEF_DEAD_BEEF_DEAD);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check("R3 write ignored by run", {dly_int, dly_frac}, 64'h12_38DC);
        cyc(0, 0, 0, 1, 0, 1, 0);
        check("R3 commit ignored by run", {dly_int, dly_frac}, 64'h12_3A62);
        check("R3 phase unchanged", 64'(ph_word), 64'h4003);

        // R2: start loads the staged set; codes 3 and 7 hit nothing
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R2 new delay value", {dly_int, dly_frac}, 64'hFFFF);
        check("R2 phase value kept", 64'(ph_word), 64'h4000);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check("R2 first diff kept", {dly_int, dly_frac}, 64'h1_017F);
        check("R2 phase diff kept", 64'(ph_word), 64'h4001);

        // R9: start with nothing pending
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R9 dropped to idle", {61'd0, dly_valid, ph_valid, run}, 0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check("R11 idle tick after drop", {dly_int, dly_frac}, 64'h1_017F);

        // R10: start + ticks + commit in one cycle
        wr(3'd4, 64'h8000_0000_0000_0000);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 1, 1);
        check("R10 start beats tick", {dly_int, dly_frac}, 64'hFFFF);
        check("R10 start beats sample", 64'(ph_word), 64'h8000);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R10 same-cycle commit still pending", 64'(run), 1);

        // R7 / R8 wrap
        wr(3'd0, 64'h0000_FFFF_FFFF_FFF0);
        wr(3'd1, 64'h20);
        wr(3'd2, 64'h0);
        wr(3'd4, 64'hFFFF_0000_0000_0000);
        wr(3'd5, 64'h0001_0000_0000_0000);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check("R7 near top", {dly_int, dly_frac}, 64'hFFFF_FFFF_FFF0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check("R7 delay wrap", {dly_int, dly_frac}, 64'h10);
        check("R8 phase wrap", 64'(ph_word), 64'h0000);

        // Random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            bit          we, cm, st, ft, sm;
            logic [2:0]  sel;
            logic [63:0] d;
            we  = ($urandom_range(0, 3) == 0);
            sel = 3'($urandom_range(0, 7));
            d   = {$urandom, $urandom};
            cm  = ($urandom_range(0, 40) == 0);
            st  = ($urandom_range(0, 60) == 0);
            ft  = ($urandom_range(0, 7) == 0);
            sm  = ($urandom_range(0, 1) == 0);
            cyc(we, sel, d, cm, st, ft, sm);
        end

        cmp_en = 1'b0;
        finish_run();
    end
endmodule